// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Digital Loop

This block is the digital control loop of a clock recovery circuit. Each cycle it takes one word of deserialized data samples together with the edge samples that were taken between neighbouring bits. From these it decides, bit by bit, whether the recovered clock is early or late. It reduces a group of those decisions to a single vote and passes that vote through a proportional-integral filter. The filter holds a binary phase code.

The top bits of the phase code select the sampling phase of the edge clock. The data clock and the auxiliary clock sit at programmable offsets from that phase. All three codes leave the block as thermometer vectors, ready to drive phase interpolators. The two gains and the data offset are normally held constant. The auxiliary offset may be changed by a separate controller at any time while the loop runs, and the auxiliary output follows it at once.

Top module: `cdr_bb_loop`

## Requirements
- R1: After reset the phase code, the integral state, the vote group and the stored last data bit are all zero, so the edge output is all zeros and the data and auxiliary outputs show only their offsets.
- R2: A bit position whose data bit equals the bit before it (bit 0 is compared with bit W-1 of the previous word) casts no vote, whatever its edge sample is. A word with no transitions therefore leaves the phase unchanged.
- R3: Bit 0 of a word is the oldest bit. At a transition, an edge sample equal to the earlier bit counts as early and moves the code up. An edge sample equal to the later bit counts as late and moves the code down.
- R4: A group whose early and late counts are equal produces a zero vote. A zero vote leaves the integral state unchanged.
- R5: Votes are taken over DECIM consecutive words, and the phase register updates only on the cycle after a group closes. The code is first visible two clock edges after the last word of the group.
- R6: On each vote, the integral state changes by plus or minus 2^ki_shift and saturates at the limits of a signed INT_W-bit value.
- R7: On each vote, the phase accumulator (P+FRAC bits) adds the integral state held before the vote plus or minus 2^kp_shift, wrapping modulo 2^(P+FRAC). The phase code is its top P bits.
- R8: The data code is (phase code + kd_off) mod 2^P and the auxiliary code is (phase code + ka_off) mod 2^P.
- R9: A code value c is output as a (2^P-1)-bit thermometer vector whose c least significant bits are ones and whose other bits are zeros.
- R10: A change of ka_off while the loop runs alters the auxiliary output in the same cycle and leaves the edge and data outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock, one data word per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | W | Data samples, bit 0 oldest |
| rx_edge | input | W | Edge sample taken before each data bit |
| ki_shift | input | GAIN_W | Integral gain as a power-of-two shift |
| kp_shift | input | GAIN_W | Proportional gain as a power-of-two shift |
| kd_off | input | P | Data clock offset in code steps |
| ka_off | input | P | Auxiliary clock offset in code steps |
| bnd_therm | output | 2^P-1 | Edge clock interpolator code, thermometer |
| dat_therm | output | 2^P-1 | Data clock interpolator code, thermometer |
| aux_therm | output | 2^P-1 | Auxiliary clock interpolator code, thermometer |

## Verification
The bench builds the block with W=8, DECIM=2, P=4, FRAC=2 and INT_W=5. With these values a single proportional step of 2^2 moves the code by exactly one position, so an early or late group can be read straight off the outputs. One late vote taken from reset wraps the code from 0 to 15, and a 16-position wrap is easy to reach. The integral range of -16..15 reaches saturation within two votes when ki_shift is 3. The offsets of 15 and 9 force the data and auxiliary codes to wrap as well.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    typedef enum logic [1:0] {
        VOTE_NONE = 2'b00,
        VOTE_UP   = 2'b01,
        VOTE_DN   = 2'b10
    } vote_e;
endpackage

// File: rtl/cdr_edge_detect.sv
module cdr_edge_detect #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  edge_s,
    output logic [CW-1:0] early_cnt,
    output logic [CW-1:0] late_cnt
);
    typedef struct packed {
        logic last;
    } st_t;

    st_t st_d, st_q;
    logic prev;

    always_comb begin
        early_cnt = '0;
        late_cnt  = '0;
        prev      = st_q.last;
        for (int i = 0; i < W; i++) begin
            if (prev != din[i]) begin
                if (edge_s[i] == prev) early_cnt = early_cnt + CW'(1);
                else                   late_cnt  = late_cnt + CW'(1);
            end
            prev = din[i];
        end
        st_d.last = din[W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a word that repeats the stored bit everywhere yields no votes
    assert_flat_word_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (din == {W{st_q.last}}) |-> (early_cnt == '0 && late_cnt == '0));
endmodule

// File: rtl/cdr_vote_decim.sv
module cdr_vote_decim
    import cdr_pkg::*;
#(
    parameter int W     = 16,
    parameter int DECIM = 4,
    localparam int CW   = $clog2(W + 1),
    localparam int NW   = (DECIM > 1) ? $clog2(DECIM) : 1,
    localparam int SW   = CW + NW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] early_cnt,
    input  logic [CW-1:0] late_cnt,
    output vote_e         vote,
    output logic          vote_vld
);
    typedef struct packed {
        logic [NW-1:0]        cnt;
        logic signed [SW-1:0] sum;
        vote_e                vote;
        logic                 vld;
    } st_t;

    st_t st_d, st_q;
    logic signed [SW-1:0] total;

    always_comb begin
        total = st_q.sum + $signed(SW'(early_cnt)) - $signed(SW'(late_cnt));
        st_d  = st_q;
        if (st_q.cnt == NW'(DECIM - 1)) begin
            st_d.cnt = '0;
            st_d.sum = '0;
            st_d.vld = 1'b1;
            if (total > 0)      st_d.vote = VOTE_UP;
            else if (total < 0) st_d.vote = VOTE_DN;
            else                st_d.vote = VOTE_NONE;
        end else begin
            st_d.cnt  = st_q.cnt + NW'(1);
            st_d.sum  = total;
            st_d.vld  = 1'b0;
            st_d.vote = VOTE_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, sum: '0, vote: VOTE_NONE, vld: 1'b0};
        else        st_q <= st_d;
    end

    assign vote     = st_q.vote;
    assign vote_vld = st_q.vld;

    generate
        if (DECIM > 1) begin : g_spacing
            // R5: a group strobe is never followed directly by another
            assert_strobe_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                vote_vld |=> !vote_vld);
        end
    endgenerate
endmodule

// File: rtl/cdr_pi_filter.sv
module cdr_pi_filter
    import cdr_pkg::*;
#(
    parameter int P      = 6,
    parameter int FRAC   = 8,
    parameter int INT_W  = 12,
    parameter int GAIN_W = 5,
    localparam int ACC_W = P + FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vote_e             vote,
    input  logic              vote_vld,
    input  logic [GAIN_W-1:0] ki_shift,
    input  logic [GAIN_W-1:0] kp_shift,
    output logic [P-1:0]      code
);
    localparam logic signed [63:0] IMAX = (64'sd1 <<< (INT_W - 1)) - 64'sd1;
    localparam logic signed [63:0] IMIN = -(64'sd1 <<< (INT_W - 1));

    typedef struct packed {
        logic signed [INT_W-1:0] integ;
        logic [ACC_W-1:0]        ph;
    } st_t;

    st_t st_d, st_q;
    logic signed [63:0] mag_i, step_i, isum;
    logic [ACC_W-1:0]   step_p, iext;

    always_comb begin
        mag_i  = 64'sd1 <<< ki_shift;
        step_i = (vote == VOTE_UP) ? mag_i : (vote == VOTE_DN) ? -mag_i : 64'sd0;
        step_p = (vote == VOTE_UP) ? (ACC_W'(1) << kp_shift)
               : (vote == VOTE_DN) ? -(ACC_W'(1) << kp_shift) : '0;
        iext   = {{(ACC_W-INT_W){st_q.integ[INT_W-1]}}, st_q.integ};
        isum   = {{(64-INT_W){st_q.integ[INT_W-1]}}, st_q.integ} + step_i;
        st_d   = st_q;
        if (vote_vld) begin
            if (isum > IMAX)      st_d.integ = INT_W'(IMAX);
            else if (isum < IMIN) st_d.integ = INT_W'(IMIN);
            else                  st_d.integ = isum[INT_W-1:0];
            st_d.ph = st_q.ph + iext + step_p;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.ph[ACC_W-1 -: P];

    // R5: phase moves only on a group strobe
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_vld |=> $stable(st_q.ph));
    // R4: a tied group leaves the integral state alone
    assert_tie_keeps_integ_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_vld && vote == VOTE_NONE) |=> $stable(st_q.integ));
    // R6: an up vote at the positive limit holds the limit
    assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_vld && vote == VOTE_UP && st_q.integ == INT_W'(IMAX)) |=> st_q.integ == INT_W'(IMAX));
    // R6: a down vote at the negative limit holds the limit
    assert_sat_bot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_vld && vote == VOTE_DN && st_q.integ == INT_W'(IMIN)) |=> st_q.integ == INT_W'(IMIN));
endmodule

// File: rtl/cdr_therm.sv
module cdr_therm #(
    parameter int P = 6,
    localparam int TW = (1 << P) - 1
) (
    input  logic [P-1:0]  code,
    output logic [TW-1:0] therm
);
    generate
        for (genvar i = 0; i < TW; i++) begin : g_bit
            assign therm[i] = (code > P'(i));
        end
    endgenerate
endmodule

// File: rtl/cdr_bb_loop.sv
module cdr_bb_loop
    import cdr_pkg::*;
#(
    parameter int W      = 16,
    parameter int DECIM  = 4,
    parameter int P      = 6,
    parameter int FRAC   = 8,
    parameter int INT_W  = 12,
    parameter int GAIN_W = 5,
    localparam int TW    = (1 << P) - 1,
    localparam int CW    = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      rx_data,
    input  logic [W-1:0]      rx_edge,
    input  logic [GAIN_W-1:0] ki_shift,
    input  logic [GAIN_W-1:0] kp_shift,
    input  logic [P-1:0]      kd_off,
    input  logic [P-1:0]      ka_off,
    output logic [TW-1:0]     bnd_therm,
    output logic [TW-1:0]     dat_therm,
    output logic [TW-1:0]     aux_therm
);
    logic [CW-1:0] early_cnt, late_cnt;
    vote_e         vote;
    logic          vote_vld;
    logic [P-1:0]  bcode;
    logic [P-1:0]  codes [3];
    logic [TW-1:0] therms [3];

    cdr_edge_detect #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .din(rx_data), .edge_s(rx_edge),
        .early_cnt(early_cnt), .late_cnt(late_cnt)
    );

    cdr_vote_decim #(.W(W), .DECIM(DECIM)) u_vote (
        .clk(clk), .rst_n(rst_n), .early_cnt(early_cnt), .late_cnt(late_cnt),
        .vote(vote), .vote_vld(vote_vld)
    );

    cdr_pi_filter #(.P(P), .FRAC(FRAC), .INT_W(INT_W), .GAIN_W(GAIN_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .vote(vote), .vote_vld(vote_vld),
        .ki_shift(ki_shift), .kp_shift(kp_shift), .code(bcode)
    );

    always_comb begin
        codes[0] = bcode;
        codes[1] = bcode + kd_off;
        codes[2] = bcode + ka_off;
    end

    generate
        for (genvar k = 0; k < 3; k++) begin : g_dec
            cdr_therm #(.P(P)) u_therm (.code(codes[k]), .therm(therms[k]));
        end
    endgenerate

    assign bnd_therm = therms[0];
    assign dat_therm = therms[1];
    assign aux_therm = therms[2];

    // R8: with phase and offsets steady, the offset outputs hold
    assert_offsets_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(bcode) && $stable(kd_off) && $stable(ka_off)) |-> ($stable(dat_therm) && $stable(aux_therm)));
endmodule

// File: tb/cdr_bb_loop_test.sv
`timescale 1ns/1ps
module cdr_bb_loop_test;
    localparam int W = 8, DECIM = 2, P = 4, FRAC = 2, INT_W = 5, GAIN_W = 5;
    localparam int TW = (1 << P) - 1;
    localparam int PM = 1 << (P + FRAC);
    localparam int IMX = (1 << (INT_W - 1)) - 1;
    localparam int IMN = -(1 << (INT_W - 1));

    // {data, edge} pairs walked against the reference model
    localparam logic [15:0] VEC [12] = '{
        16'h55AA, 16'h55AA, 16'h0F10, 16'h0F0F, 16'h3366, 16'hCC99,
        16'hFF00, 16'h00FF, 16'hA554, 16'hA5A5, 16'h1E3C, 16'hF0F0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] rx_data = '0, rx_edge = '0;
    logic [GAIN_W-1:0] ki_shift = '0, kp_shift = 5'd2;
    logic [P-1:0] kd_off = 4'd3, ka_off = 4'd5;
    logic [TW-1:0] bnd_therm, dat_therm, aux_therm;

    int total = 0, bad = 0;
    bit done = 0;
    int m_last, m_cnt, m_sum, m_vote, m_vld, m_i, m_ph;

    always #2 clk = ~clk;

    cdr_bb_loop #(.W(W), .DECIM(DECIM), .P(P), .FRAC(FRAC), .INT_W(INT_W), .GAIN_W(GAIN_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_edge(rx_edge),
        .ki_shift(ki_shift), .kp_shift(kp_shift), .kd_off(kd_off), .ka_off(ka_off),
        .bnd_therm(bnd_therm), .dat_therm(dat_therm), .aux_therm(aux_therm)
    );

    function automatic logic [TW-1:0] th(int c);
        logic [TW-1:0] t = '0;
        for (int i = 0; i < TW; i++) t[i] = (i < c);
        return t;
    endfunction

    task automatic chk(string tag, logic [3*TW-1:0] got, logic [3*TW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_model(string tag);
        int bc = m_ph >> FRAC;
        chk(tag, {bnd_therm, dat_therm, aux_therm},
            {th(bc), th((bc + kd_off) % 16), th((bc + ka_off) % 16)});
    endtask

    task automatic chk_code(string tag, int bc);
        chk(tag, {bnd_therm, 30'h0}, {th(bc), 30'h0});
    endtask

    task automatic model_reset();
        m_last = 0; m_cnt = 0; m_sum = 0; m_vote = 0; m_vld = 0; m_i = 0; m_ph = 0;
    endtask

    task automatic model_step(logic [W-1:0] d, logic [W-1:0] e);
        int ec = 0, lc = 0, prv = m_last, tot, ni;
        if (m_vld != 0) begin
            ni = m_i + m_vote * (1 << ki_shift);
            if (ni > IMX) ni = IMX;
            if (ni < IMN) ni = IMN;
            m_ph = (((m_ph + m_i + m_vote * (1 << kp_shift)) % PM) + PM) % PM;
            m_i = ni;
        end
        for (int i = 0; i < W; i++) begin
            if (prv != int'(d[i])) begin
                if (int'(e[i]) == prv) ec++; else lc++;
            end
            prv = int'(d[i]);
        end
        tot = m_sum + ec - lc;
        if (m_cnt == DECIM - 1) begin
            m_vld = 1; m_vote = (tot > 0) ? 1 : (tot < 0) ? -1 : 0; m_sum = 0; m_cnt = 0;
        end else begin
            m_vld = 0; m_vote = 0; m_sum = tot; m_cnt++;
        end
        m_last = int'(d[W-1]);
    endtask

    task automatic drive(logic [W-1:0] d, logic [W-1:0] e);
        rx_data = d; rx_edge = e;
        @(posedge clk);
        model_step(d, e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_data = '0; rx_edge = '0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state, data shows kd=3, aux shows ka=5
        chk("R1 reset", {bnd_therm, dat_therm, aux_therm}, {15'h0, 15'h0007, 15'h001F});

        // R3/R5: two all-early words, code appears two edges after the group
        drive(8'h55, 8'hAA); chk_code("R5 mid group", 0);
        drive(8'h55, 8'hAA); chk_code("R5 strobe only", 0);
        drive(8'h00, 8'h00); chk_code("R3 early moves up", 1);

        // R3/R7: all-late group wraps the code from 0 to 15
        do_reset();
        drive(8'h55, 8'h55); drive(8'h55, 8'h55); drive(8'h00, 8'h00);
        chk_code("R7 wrap below zero", 15);
        chk_model("R8 offsets wrap");

        // R4: tie across a group gives no movement
        do_reset();
        drive(8'h55, 8'hAA); drive(8'h55, 8'h55); drive(8'h00, 8'h00);
        chk_code("R4 tie", 0);
        drive(8'h00, 8'h00); drive(8'h00, 8'h00);
        chk_code("R4 tie integ unchanged", 0);

        // R2: no transitions with arbitrary edges
        do_reset();
        for (int k = 0; k < 4; k++) drive(8'h00, 8'hFF);
        chk_code("R2 flat word", 0);

        // R3/R9: table of mixed patterns against the model
        do_reset();
        ki_shift = 5'd1;
        for (int k = 0; k < 12; k++) begin
            drive(VEC[k][15:8], VEC[k][7:0]);
            chk_model("R9 table");
        end

        // R6: integral saturation under a long run of early groups
        do_reset();
        ki_shift = 5'd3; kp_shift = 5'd0;
        for (int k = 0; k < 14; k++) begin
            drive(8'h55, 8'hAA);
            chk_model("R6 saturate");
        end
        for (int k = 0; k < 20; k++) begin
            drive(8'h55, 8'h55);
            chk_model("R6 saturate low");
        end

        // R8/R10: offsets wrap; auxiliary offset changes take effect at once
        kd_off = 4'd15; ka_off = 4'd9; #1;
        chk_model("R8 new offsets");
        ka_off = 4'd2; #1;
        chk_model("R10 aux follows");
        drive(8'h00, 8'h00);
        chk_model("R10 after edge");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule